// File: doc/BRIEF.md
# I2C Interrupt Request Flag Generator

This block produces the single interrupt request flag of an I2C controller that can act as bus master or as slave. A separate bit-level engine reports bus events to it as one-cycle pulses: start and stop detection, SCL rising and falling edges, own-address match, general-call address (already qualified by a write direction bit), arbitration loss, and the value of the received acknowledge bit. From these pulses the block tracks where each frame stands and which session state applies. It then raises a sticky flag according to the operating mode and a small set of control levels.

Software clears the flag with a two-step handshake: it reads the flag while the flag is 1, then writes 0. The flag drives the interrupt line directly. While the flag is set and wait insertion is enabled, the block asks the bit engine to hold SCL low, so the bus stalls until software has serviced the event. All inputs and outputs are plain control and status signals. There is no data stream at this boundary, so there is no valid/ready handshake.

Top module: `i2c_irq_flag`

## Requirements
- R1: After reset, `flag`, `irq` and `scl_hold` are all 0.
- R2: A `start_det` pulse sets the flag when `master_mode`=1 and an `issue_start` pulse has been seen since the last `start_det`.
- R3: SCL rising edges are counted from 0 after each `start_det`, and the count wraps after the 9th rise. With `master_mode`=1 and `wait_en`=1, an `scl_fall` seen while 8 rises have been counted sets the flag, and the 9th rise does not set it.
- R4: With `master_mode`=1 and `wait_en`=0, the 9th `scl_rise` of a frame sets the flag, and the falling edge after the 8th rise does not.
- R5: After an `arb_lost` pulse, the 9th rise of the first frame following a `start_det` sets the flag. This arbitration-lost state is cleared by `stop_det`.
- R6: With `ack_chk_en`=1, a 9th rise with `ack_in`=1 sets the flag in either mode.
- R7: An `arb_lost` pulse sets the flag when `al_ie`=1.
- R8: With `master_mode`=0, once `addr_match` has pulsed, every 9th rise sets the flag. The 9th rise on which the pulse itself arrives also sets it. This lasts until the next `start_det` or `stop_det`.
- R9: With `master_mode`=0, once `gen_call` has pulsed, every 9th rise sets the flag until the next `start_det` or `stop_det`.
- R10: With `master_mode`=0, a `stop_det` pulse sets the flag only when `stop_mask`=0.
- R11: A write with `flag_wdata`=0 clears the flag only if the last read of the flag since the previous write returned 1. A write of 1 leaves the flag unchanged. A write of 0 without such a read leaves the flag unchanged.
- R12: When a set condition and a valid clear occur in the same cycle, the flag ends up 1.
- R13: `irq` equals `flag`, and `scl_hold` equals `flag` AND `wait_en`. The flag changes one clock after its cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_mode | input | 1 | 1 = master, 0 = slave |
| issue_start | input | 1 | Pulse: this controller has issued a start |
| start_det | input | 1 | Pulse: start or repeated start seen on the bus |
| stop_det | input | 1 | Pulse: stop seen on the bus |
| scl_rise | input | 1 | Pulse: SCL rising edge |
| scl_fall | input | 1 | Pulse: SCL falling edge |
| addr_match | input | 1 | Pulse: own slave address matched |
| gen_call | input | 1 | Pulse: general-call address with write direction |
| arb_lost | input | 1 | Pulse: arbitration lost |
| ack_in | input | 1 | Received acknowledge bit, valid on the 9th rise |
| wait_en | input | 1 | Wait insertion enable |
| ack_chk_en | input | 1 | Acknowledge checking enable |
| al_ie | input | 1 | Arbitration-lost interrupt enable |
| stop_mask | input | 1 | 1 masks the stop interrupt in slave mode |
| flag_rd | input | 1 | CPU read strobe of the flag |
| flag_wr | input | 1 | CPU write strobe of the flag |
| flag_wdata | input | 1 | CPU write data for the flag |
| flag | output | 1 | Sticky interrupt request flag |
| irq | output | 1 | Interrupt line to the CPU |
| scl_hold | output | 1 | Request to the bit engine to hold SCL low |

## Verification
The assertions check on every cycle that the bit count stays inside one frame and that a stop wipes the slave session state. They also check that the flag never rises without a set condition, never falls without a write of 0, and that a set condition always leaves the flag at 1 one cycle later. Whether the right event sets the flag in the right mode and at the right SCL edge can only be shown by the bench's scenarios. The same holds for the clear handshake ignoring stray writes: it depends on history over many cycles, which the bench's reference model follows through directed frames and long random event streams.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

  // control levels that select which events raise the flag
  typedef struct packed {
    logic master;
    logic wait_en;
    logic ack_chk;
    logic al_ie;
    logic stop_mask;
  } irq_ctl_t;

  // frame position events derived from the SCL edge count
  typedef struct packed {
    logic rise_last;   // rising edge that completes a frame
    logic fall_pre;    // falling edge just before the acknowledge slot
    logic first;       // first frame after a start is in progress
  } frame_evt_t;

  // session state latched from bus events
  typedef struct packed {
    logic own_start;
    logic al_seen;
    logic addr_sess;
    logic gc_sess;
  } sess_t;

endpackage

// File: rtl/i2c_frame_track.sv
module i2c_frame_track
  import i2c_irq_pkg::*;
#(
  parameter int BITS = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_det,
  input  logic       scl_rise,
  input  logic       scl_fall,
  output frame_evt_t evt
);
  localparam int CW   = $clog2(BITS);
  localparam int LAST = BITS - 1;

  logic [CW-1:0] cnt_q;
  logic          first_q;
  logic          at_last;

  assign at_last       = (cnt_q == CW'(LAST));
  assign evt.rise_last = scl_rise && at_last;
  assign evt.fall_pre  = scl_fall && at_last;
  assign evt.first     = first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else if (start_det) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else if (scl_rise) begin
      cnt_q <= at_last ? '0 : cnt_q + 1'b1;
      if (at_last) first_q <= 1'b0;
    end
  end

  AST_CNT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LAST)); // R3

endmodule

// File: rtl/i2c_session_track.sv
module i2c_session_track
  import i2c_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     master,
  input  logic     issue_start,
  input  logic     start_det,
  input  logic     stop_det,
  input  logic     addr_match,
  input  logic     gen_call,
  input  logic     arb_lost,
  output sess_t    sess
);
  logic own_q, al_q, aas_q, adz_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= 1'b0;
      al_q  <= 1'b0;
      aas_q <= 1'b0;
      adz_q <= 1'b0;
    end else begin
      if (start_det)        own_q <= 1'b0;
      else if (issue_start) own_q <= 1'b1;

      if (stop_det)         al_q <= 1'b0;
      else if (arb_lost)    al_q <= 1'b1;

      if (start_det || stop_det) begin
        aas_q <= 1'b0;
        adz_q <= 1'b0;
      end else begin
        if (addr_match && !master) aas_q <= 1'b1;
        if (gen_call && !master)   adz_q <= 1'b1;
      end
    end
  end

  assign sess.own_start = own_q;
  assign sess.al_seen   = al_q;
  assign sess.addr_sess = aas_q;
  assign sess.gc_sess   = adz_q;

  AST_STOP_ENDS_SESSION: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!aas_q && !adz_q)); // R8

endmodule

// File: rtl/i2c_irq_set_logic.sv
module i2c_irq_set_logic
  import i2c_irq_pkg::*;
(
  input  irq_ctl_t   ctl,
  input  frame_evt_t fr,
  input  sess_t      sess,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       addr_match,
  input  logic       gen_call,
  input  logic       arb_lost,
  input  logic       ack_in,
  output logic       set_evt
);
  logic m_start, m_xfer, al_addr, ack_nak, al_int, s_frame, s_stop;

  always_comb begin
    m_start = ctl.master && start_det && sess.own_start;
    m_xfer  = ctl.master && (ctl.wait_en ? fr.fall_pre : fr.rise_last);
    al_addr = sess.al_seen && fr.first && fr.rise_last;
    ack_nak = ctl.ack_chk && fr.rise_last && ack_in;
    al_int  = ctl.al_ie && arb_lost;
    s_frame = !ctl.master && fr.rise_last &&
              (sess.addr_sess || addr_match || sess.gc_sess || gen_call);
    s_stop  = !ctl.master && stop_det && !ctl.stop_mask;
    set_evt = m_start || m_xfer || al_addr || ack_nak || al_int || s_frame || s_stop;
  end

endmodule

// File: rtl/i2c_irq_flag.sv
module i2c_irq_flag
  import i2c_irq_pkg::*;
#(
  parameter int FRAME_BITS = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master_mode,
  input  logic issue_start,
  input  logic start_det,
  input  logic stop_det,
  input  logic scl_rise,
  input  logic scl_fall,
  input  logic addr_match,
  input  logic gen_call,
  input  logic arb_lost,
  input  logic ack_in,
  input  logic wait_en,
  input  logic ack_chk_en,
  input  logic al_ie,
  input  logic stop_mask,
  input  logic flag_rd,
  input  logic flag_wr,
  input  logic flag_wdata,
  output logic flag,
  output logic irq,
  output logic scl_hold
);
  irq_ctl_t   ctl;
  frame_evt_t fr;
  sess_t      sess;
  logic       set_evt;
  logic       flag_q, armed_q, clr_ok;

  assign ctl = '{master: master_mode, wait_en: wait_en, ack_chk: ack_chk_en,
                 al_ie: al_ie, stop_mask: stop_mask};

  i2c_frame_track #(.BITS(FRAME_BITS)) u_frame (
    .clk(clk), .rst_n(rst_n), .start_det(start_det),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .evt(fr));

  i2c_session_track u_sess (
    .clk(clk), .rst_n(rst_n), .master(master_mode), .issue_start(issue_start),
    .start_det(start_det), .stop_det(stop_det), .addr_match(addr_match),
    .gen_call(gen_call), .arb_lost(arb_lost), .sess(sess));

  i2c_irq_set_logic u_set (
    .ctl(ctl), .fr(fr), .sess(sess), .start_det(start_det), .stop_det(stop_det),
    .addr_match(addr_match), .gen_call(gen_call), .arb_lost(arb_lost),
    .ack_in(ack_in), .set_evt(set_evt));

  assign clr_ok = flag_wr && !flag_wdata && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (flag_wr)              armed_q <= 1'b0;
      else if (flag_rd && flag_q) armed_q <= 1'b1;

      if (set_evt)     flag_q <= 1'b1;
      else if (clr_ok) flag_q <= 1'b0;
    end
  end

  assign flag     = flag_q;
  assign irq      = flag_q;
  assign scl_hold = flag_q && wait_en;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q); // R12
  AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(set_evt)); // R2
  AST_FALL_NEEDS_WRITE0: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(flag_wr && !flag_wdata)); // R11

endmodule

// File: tb/tb_i2c_irq_flag.sv
module tb_i2c_irq_flag;
  logic clk = 0, rst_n = 0;
  logic master_mode = 0, issue_start = 0, start_det = 0, stop_det = 0;
  logic scl_rise = 0, scl_fall = 0, addr_match = 0, gen_call = 0, arb_lost = 0;
  logic ack_in = 0, wait_en = 0, ack_chk_en = 0, al_ie = 0, stop_mask = 1;
  logic flag_rd = 0, flag_wr = 0, flag_wdata = 0;
  logic flag, irq, scl_hold;

  int n_chk = 0, n_bad = 0, cycles = 0;
  bit done = 0;

  // reference model state
  int m_cnt; bit m_first, m_own, m_al, m_aas, m_adz, m_armed, m_flag;

  always #5 clk = ~clk;

  i2c_irq_flag dut (.*);

  function automatic bit model_set();
    bit r9 = scl_rise && m_cnt == 8;
    bit f8 = scl_fall && m_cnt == 8;
    return (master_mode && start_det && m_own) ||
           (master_mode && (wait_en ? f8 : r9)) ||
           (m_al && m_first && r9) ||
           (ack_chk_en && r9 && ack_in) ||
           (al_ie && arb_lost) ||
           (!master_mode && r9 && (m_aas || addr_match || m_adz || gen_call)) ||
           (!master_mode && stop_det && !stop_mask);
  endfunction

  task automatic model_step();
    bit s = model_set();
    bit r9 = scl_rise && m_cnt == 8;
    bit clr = flag_wr && !flag_wdata && m_armed;
    if (flag_wr) m_armed = 0; else if (flag_rd && m_flag) m_armed = 1;
    if (s) m_flag = 1; else if (clr) m_flag = 0;
    if (start_det) m_own = 0; else if (issue_start) m_own = 1;
    if (stop_det) m_al = 0; else if (arb_lost) m_al = 1;
    if (start_det || stop_det) begin m_aas = 0; m_adz = 0; end
    else begin
      if (addr_match && !master_mode) m_aas = 1;
      if (gen_call && !master_mode) m_adz = 1;
    end
    if (start_det) begin m_cnt = 0; m_first = 1; end
    else if (scl_rise) begin
      if (r9) m_first = 0;
      m_cnt = r9 ? 0 : m_cnt + 1;
    end
  endtask

  task automatic check(string req);
    bit eh = m_flag && wait_en;
    n_chk++;
    if (flag !== m_flag || irq !== m_flag || scl_hold !== eh) begin
      n_bad++;
      $display("FAIL %s: flag/irq/hold=%0b/%0b/%0b expected %0b/%0b/%0b",
               req, flag, irq, scl_hold, m_flag, m_flag, eh);
    end
  endtask

  task automatic clr_pulses();
    issue_start = 0; start_det = 0; stop_det = 0; scl_rise = 0; scl_fall = 0;
    addr_match = 0; gen_call = 0; arb_lost = 0; flag_rd = 0; flag_wr = 0;
    flag_wdata = 0; ack_in = 0;
  endtask

  task automatic tick(string req);
    model_step();
    @(posedge clk); #1;
    check(req);
    clr_pulses();
  endtask

  task automatic do_reset();
    rst_n = 0; clr_pulses();
    m_cnt = 0; m_first = 0; m_own = 0; m_al = 0; m_aas = 0; m_adz = 0;
    m_armed = 0; m_flag = 0;
    repeat (2) @(posedge clk); #1;
    rst_n = 1;
  endtask

  task automatic cpu_clear(string req);
    flag_rd = 1; tick(req);
    flag_wr = 1; flag_wdata = 0; tick(req);
  endtask

  // one frame of 9 SCL pulses; extras applied on the 9th rise
  task automatic frame(string req, bit ackv, bit am, bit gc);
    for (int i = 0; i < 9; i++) begin
      scl_rise = 1;
      if (i == 8) begin ack_in = ackv; addr_match = am; gen_call = gc; end
      tick(req);
      scl_fall = 1; tick(req);
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    do_reset();
    check("R1");
    // R2 master start
    master_mode = 1; issue_start = 1; tick("R2");
    start_det = 1; tick("R2");
    cpu_clear("R11");
    // R4 no wait: set on 9th rise
    wait_en = 0; frame("R4", 0, 0, 0);
    cpu_clear("R11");
    // R3 wait: set on falling edge after 8th rise, hold SCL (R13)
    wait_en = 1; frame("R3", 0, 0, 0);
    check("R13");
    cpu_clear("R11");
    wait_en = 0;
    // R7 arbitration interrupt, R5 address after loss
    al_ie = 1; arb_lost = 1; tick("R7");
    cpu_clear("R7");
    al_ie = 0; master_mode = 0; start_det = 1; tick("R5");
    frame("R5", 0, 0, 0);
    cpu_clear("R5");
    stop_det = 1; tick("R10");
    // R6 ack check in slave mode
    ack_chk_en = 1; start_det = 1; tick("R6");
    frame("R6", 1, 0, 0);
    cpu_clear("R6");
    ack_chk_en = 0;
    // R8 address session
    start_det = 1; tick("R8");
    frame("R8", 0, 1, 0); cpu_clear("R8");
    frame("R8", 0, 0, 0); cpu_clear("R8");
    stop_mask = 1; stop_det = 1; tick("R10");
    frame("R8", 0, 0, 0);
    // R9 general call session
    start_det = 1; tick("R9");
    frame("R9", 0, 0, 1); cpu_clear("R9");
    frame("R9", 0, 0, 0); cpu_clear("R9");
    start_det = 1; tick("R9");
    frame("R9", 0, 0, 0);
    // R10 stop with mask clear
    stop_mask = 0; stop_det = 1; tick("R10");
    // R11 stray writes
    flag_wr = 1; flag_wdata = 0; tick("R11");
    flag_rd = 1; tick("R11");
    flag_wr = 1; flag_wdata = 1; tick("R11");
    flag_wr = 1; flag_wdata = 0; tick("R11");
    // R12 set coincides with valid clear
    flag_rd = 1; tick("R12");
    al_ie = 1; arb_lost = 1; flag_wr = 1; flag_wdata = 0; tick("R12");
    cpu_clear("R12");
    al_ie = 0;
    // random event stream
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      int ev = $urandom_range(0, 19);
      if ($urandom_range(0, 31) == 0) begin
        master_mode = 1'($urandom); wait_en = 1'($urandom);
        ack_chk_en = 1'($urandom); al_ie = 1'($urandom); stop_mask = 1'($urandom);
      end
      case (ev)
        0: start_det = 1;
        1: stop_det = 1;
        2: issue_start = 1;
        3: arb_lost = 1;
        4,5,6,7: begin scl_rise = 1; ack_in = 1'($urandom);
                   addr_match = ($urandom_range(0, 7) == 0);
                   gen_call = ($urandom_range(0, 9) == 0); end
        8,9,10,11: scl_fall = 1;
        12: flag_rd = 1;
        13: begin flag_wr = 1; flag_wdata = 1'($urandom); end
        default: ;
      endcase
      tick("R13");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        n_bad++;
        $display("FAIL watchdog: cycles=%0d expected completion", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end
endmodule